// File: doc/BRIEF.md
# BCD Calendar Real-Time Counter

This block keeps wall-clock time as packed BCD fields: seconds, minutes, hours, a weekday number, day of month, month and a four-digit year. The year is held as one 16-bit word, with the century in the upper byte and the year within the century in the lower byte. A 128 Hz strobe from an external prescaler advances a sub-second counter. Each time that counter wraps, the seconds field steps forward, and a carry ripples through the calendar. The ripple follows month lengths, including February in leap years.

Software reaches the block through a small word-indexed register port. It stops the clock and holds the prescaler in reset, loads the time fields, and then restarts counting. A read sequence across several fields can be torn by a seconds step. To guard against this, the block sets a carry flag on every seconds advance. Software clears the flag, reads the fields, and retries if the flag has come back. The flag can also drive an interrupt line.

Top module: `bcd_rtc`

## Requirements
- R1: After reset, the fields read as follows. Sub-second 0, seconds 00, minutes 00, hours 00, weekday 0, day 01, month 01, year 16'h2000, and both control words 0. The interrupt output is low. The word index map is: 0 sub-second, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day, 6 month, 7 year, 14 flag/interrupt control, 15 run control. Bytes-wide fields read in bits 7:0.
- R2: Counting happens only when all three run-control bits (word 15) hold the right values: bit 0 (start) is 1, bit 3 (enable) is 1, and bit 1 (prescaler reset) is 0. Otherwise strobes change no field.
- R3: While running, each strobe increments the sub-second counter, which wraps from 127 to 0. Word 0 is read-only, so writes to it are ignored.
- R4: On each sub-second wrap, the seconds field advances by one BCD step (09 to 10, 59 to 00).
- R5: A seconds wrap from 59 carries into minutes. Minutes 59 carries into hours. Hours 23 carries into the day, and the same carry moves the weekday 0..6 cyclically.
- R6: The day wraps to 01 after 30 in months 04, 06, 09 and 11. It wraps after 31 in the other months except February.
- R7: February ends on 29 when the binary year is a leap year and on 28 otherwise. A year is a leap year when it is divisible by 4, except that a century year must be divisible by 400.
- R8: A day wrap carries into the month. A wrap from month 12 to 01 carries into the year. A wrap of the year byte from 99 carries into the century byte.
- R9: Word 14 bit 7 is the carry flag, which is set on every seconds advance. Writing bit 7 as 0 clears the flag, and writing it as 1 leaves it unchanged.
- R10: Word 14 bit 4 is the carry interrupt enable. The interrupt output is high exactly while the flag and the enable are both 1.
- R11: While the prescaler reset bit is 1, the sub-second counter is held at 0 and no field advances.
- R12: A field write takes effect in the next cycle even while the clock is running. If a flag-clearing write and a seconds advance fall in the same cycle, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle strobe at the sub-second rate |
| we | input | 1 | Register write strobe |
| addr | input | 4 | Word index for reads and writes |
| wdata | input | 16 | Write data; byte fields use bits 7:0 |
| rdata | output | 16 | Read data for `addr`, combinational |
| carry_irq | output | 1 | Carry interrupt request |

## Verification
The range checks on the time fields assume that software writes only valid BCD values within each field's range. They also assume that any written day fits the written month. The stimulus builds every date from a binary value chosen inside those limits and converts it to BCD, so no out-of-range field ever enters the counter. Random dates lean towards the last second, hour, day and month, so that carries ripple through several fields. Directed dates cover the February and century cases.

// File: rtl/bcd_rtc.sv
module bcd_rtc #(
  parameter int TPS = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic        we,
  input  logic [3:0]  addr,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        carry_irq
);
  localparam int SW = (TPS > 1) ? $clog2(TPS) : 1;
  localparam logic [SW-1:0] SUB_TOP = SW'(TPS - 1);

  function automatic logic [7:0] bcd_inc(input logic [7:0] v);
    return (v[3:0] == 4'd9) ? {v[7:4] + 4'd1, 4'd0} : {v[7:4], v[3:0] + 4'd1};
  endfunction

  logic [SW-1:0] r_sub;
  logic [7:0]    r_sec, r_min, r_hr, r_wd, r_day, r_mon;
  logic [15:0]   r_yr;
  logic          cf, cie, c_go, c_prst, c_en;

  logic          running, adv, wrap;
  logic          k_min, k_hr, k_day, k_mon, k_yr, k_cen;
  logic [7:0]    leap_src, mlen;
  logic [4:0]    leap_sum;
  logic          leap;
  logic [15:0]   wsel;
  logic [7:0]    n_sec, n_min, n_hr, n_wd, n_day, n_mon, n_ylo, n_yhi;

  assign wsel    = we ? (16'd1 << addr) : 16'd0;
  assign running = c_go & c_en & ~c_prst;
  assign adv     = running & tick;
  assign wrap    = adv & (r_sub == SUB_TOP);

  assign leap_src = (r_yr[7:0] == 8'h00) ? r_yr[15:8] : r_yr[7:0];
  assign leap_sum = {leap_src[7:4], 1'b0} + {1'b0, leap_src[3:0]};
  assign leap     = (leap_sum[1:0] == 2'b00);

  always_comb begin
    case (r_mon)
      8'h02:                      mlen = leap ? 8'h29 : 8'h28;
      8'h04, 8'h06, 8'h09, 8'h11: mlen = 8'h30;
      default:                    mlen = 8'h31;
    endcase
  end

  assign k_min = wrap  & (r_sec == 8'h59);
  assign k_hr  = k_min & (r_min == 8'h59);
  assign k_day = k_hr  & (r_hr  == 8'h23);
  assign k_mon = k_day & (r_day == mlen);
  assign k_yr  = k_mon & (r_mon == 8'h12);
  assign k_cen = k_yr  & (r_yr[7:0] == 8'h99);

  assign n_sec = !wrap  ? r_sec : (r_sec == 8'h59) ? 8'h00 : bcd_inc(r_sec);
  assign n_min = !k_min ? r_min : (r_min == 8'h59) ? 8'h00 : bcd_inc(r_min);
  assign n_hr  = !k_hr  ? r_hr  : (r_hr  == 8'h23) ? 8'h00 : bcd_inc(r_hr);
  assign n_wd  = !k_day ? r_wd  : (r_wd  == 8'h06) ? 8'h00 : r_wd + 8'h01;
  assign n_day = !k_day ? r_day : k_mon ? 8'h01 : bcd_inc(r_day);
  assign n_mon = !k_mon ? r_mon : k_yr  ? 8'h01 : bcd_inc(r_mon);
  assign n_ylo = !k_yr  ? r_yr[7:0]  : k_cen ? 8'h00 : bcd_inc(r_yr[7:0]);
  assign n_yhi = !k_cen ? r_yr[15:8] : (r_yr[15:8] == 8'h99) ? 8'h00 : bcd_inc(r_yr[15:8]);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      r_sub  <= '0;
      r_sec  <= 8'h00;
      r_min  <= 8'h00;
      r_hr   <= 8'h00;
      r_wd   <= 8'h00;
      r_day  <= 8'h01;
      r_mon  <= 8'h01;
      r_yr   <= 16'h2000;
      cf     <= 1'b0;
      cie    <= 1'b0;
      c_go   <= 1'b0;
      c_prst <= 1'b0;
      c_en   <= 1'b0;
    end else begin
      if (c_prst)   r_sub <= '0;
      else if (adv) r_sub <= wrap ? '0 : r_sub + 1'b1;
      r_sec <= wsel[1] ? wdata[7:0] : n_sec;
      r_min <= wsel[2] ? wdata[7:0] : n_min;
      r_hr  <= wsel[3] ? wdata[7:0] : n_hr;
      r_wd  <= wsel[4] ? wdata[7:0] : n_wd;
      r_day <= wsel[5] ? wdata[7:0] : n_day;
      r_mon <= wsel[6] ? wdata[7:0] : n_mon;
      r_yr  <= wsel[7] ? wdata : {n_yhi, n_ylo};
      if (wrap)                      cf <= 1'b1;
      else if (wsel[14] && !wdata[7]) cf <= 1'b0;
      if (wsel[14]) cie <= wdata[4];
      if (wsel[15]) begin
        c_go   <= wdata[0];
        c_prst <= wdata[1];
        c_en   <= wdata[3];
      end
    end
  end

  assign carry_irq = cf & cie;

  always_comb begin
    case (addr)
      4'd0:    rdata = 16'(r_sub);
      4'd1:    rdata = {8'h00, r_sec};
      4'd2:    rdata = {8'h00, r_min};
      4'd3:    rdata = {8'h00, r_hr};
      4'd4:    rdata = {8'h00, r_wd};
      4'd5:    rdata = {8'h00, r_day};
      4'd6:    rdata = {8'h00, r_mon};
      4'd7:    rdata = r_yr;
      4'd14:   rdata = {8'h00, cf, 2'b00, cie, 4'h0};
      4'd15:   rdata = {12'h000, c_en, 1'b0, c_prst, c_go};
      default: rdata = 16'h0000;
    endcase
  end
endmodule

// File: rtl/bcd_rtc_chk.sv
module rtc_chk #(
  parameter int TPS = 128
) (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic        we,
  input logic [3:0]  addr,
  input logic [15:0] wdata,
  input logic        carry_irq,
  input logic [((TPS > 1) ? $clog2(TPS) : 1)-1:0] r_sub,
  input logic [7:0]  r_sec,
  input logic [7:0]  r_min,
  input logic [7:0]  r_hr,
  input logic [7:0]  r_wd,
  input logic [7:0]  r_day,
  input logic [7:0]  r_mon,
  input logic        cf,
  input logic        cie,
  input logic        running,
  input logic        c_prst
);
  localparam int SW = (TPS > 1) ? $clog2(TPS) : 1;
  localparam logic [SW-1:0] SUB_TOP = SW'(TPS - 1);

  AST_STOP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (!running && !we) |=> ($stable(r_sec) && $stable(r_min) && $stable(r_hr) && $stable(r_day))); // R2
  AST_WRAP_CARRY: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && r_sub == SUB_TOP) |=> (cf && r_sub == '0)); // R9
  AST_SEC_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (running && tick && r_sub == SUB_TOP && !(we && addr == 4'd1)) |=> (r_sec != $past(r_sec))); // R4
  AST_SEC_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (r_sec[3:0] <= 4'd9 && r_sec <= 8'h59)); // R4
  AST_DATE_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    (r_day != 8'h00 && r_mon != 8'h00 && r_mon <= 8'h12)); // R6
  AST_WD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (r_wd <= 8'h06)); // R5
  AST_IRQ_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(carry_irq) |-> cie); // R10
  AST_PRESC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    c_prst |=> (r_sub == '0)); // R11
  AST_CF_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 4'd14 && !wdata[7] && !(running && tick && r_sub == SUB_TOP)) |=> !cf); // R9
  AST_WRITE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == 4'd2) |=> (r_min == $past(wdata[7:0]))); // R12
endmodule

bind bcd_rtc rtc_chk #(.TPS(TPS)) u_chk (.*);

// File: tb/sim_bcd_rtc.sv
`timescale 1ns/1ps
module sim_bcd_rtc;
  localparam int TPS = 128;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        we = 1'b0;
  logic [3:0]  addr = 4'd0;
  logic [15:0] wdata = 16'h0000;
  logic [15:0] rdata;
  logic        carry_irq;
  int total = 0;
  int bad = 0;
  logic [15:0] v;

  always #2 clk = ~clk;

  bcd_rtc #(.TPS(TPS)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .we(we), .addr(addr),
    .wdata(wdata), .rdata(rdata), .carry_irq(carry_irq)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    @(negedge clk);
    addr = a; wdata = d; we = 1'b1;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [15:0] r);
    @(negedge clk);
    addr = a;
    #1 r = rdata;
  endtask

  task automatic ticks(input int n);
    @(negedge clk);
    tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  function automatic logic [7:0] bb(input int x);
    return 8'(((x / 10) % 10) * 16 + (x % 10));
  endfunction

  function automatic bit is_leap(input int y);
    return (y % 4 == 0) && ((y % 100 != 0) || (y % 400 == 0));
  endfunction

  function automatic int days_in(input int m, input int y);
    if (m == 2) return is_leap(y) ? 29 : 28;
    if (m == 4 || m == 6 || m == 9 || m == 11) return 30;
    return 31;
  endfunction

  task automatic set_time(input int y, input int mo, input int d, input int wd,
                          input int h, input int mi, input int s);
    wr(4'd15, 16'h0002);
    wr(4'd1, {8'h00, bb(s)});
    wr(4'd2, {8'h00, bb(mi)});
    wr(4'd3, {8'h00, bb(h)});
    wr(4'd4, {8'h00, bb(wd)});
    wr(4'd5, {8'h00, bb(d)});
    wr(4'd6, {8'h00, bb(mo)});
    wr(4'd7, {bb(y / 100), bb(y % 100)});
    wr(4'd14, 16'h0000);
    wr(4'd15, 16'h0009);
  endtask

  task automatic check_next(input string tag, input int y, input int mo, input int d,
                            input int wd, input int h, input int mi, input int s);
    logic [15:0] r;
    int ny, nmo, nd, nwd, nh, nmi, ns;
    set_time(y, mo, d, wd, h, mi, s);
    ticks(TPS - 1);
    rd(4'd1, r); chk({tag, " sec before wrap"}, r, {8'h00, bb(s)});
    rd(4'd14, r); chk("R9 flag clear before wrap", r, 16'h0000);
    ticks(1);
    ny = y; nmo = mo; nd = d; nwd = wd; nh = h; nmi = mi; ns = s + 1;
    if (ns == 60) begin ns = 0; nmi++; end
    if (nmi == 60) begin nmi = 0; nh++; end
    if (nh == 24) begin nh = 0; nd++; nwd = (nwd + 1) % 7; end
    if (nd > days_in(mo, y)) begin nd = 1; nmo++; end
    if (nmo == 13) begin nmo = 1; ny = (ny + 1) % 10000; end
    rd(4'd1, r); chk({tag, " sec"}, r, {8'h00, bb(ns)});
    rd(4'd2, r); chk({tag, " min"}, r, {8'h00, bb(nmi)});
    rd(4'd3, r); chk({tag, " hour"}, r, {8'h00, bb(nh)});
    rd(4'd4, r); chk({tag, " weekday"}, r, {8'h00, bb(nwd)});
    rd(4'd5, r); chk({tag, " day"}, r, {8'h00, bb(nd)});
    rd(4'd6, r); chk({tag, " month"}, r, {8'h00, bb(nmo)});
    rd(4'd7, r); chk({tag, " year"}, r, {bb(ny / 100), bb(ny % 100)});
    rd(4'd14, r); chk("R9 flag set on advance", r, 16'h0080);
  endtask

  initial begin
    #(4 * 150000);
    total++; bad++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'd4711);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    rd(4'd0, v);  chk("R1 subsec", v, 16'h0000);
    rd(4'd1, v);  chk("R1 sec", v, 16'h0000);
    rd(4'd2, v);  chk("R1 min", v, 16'h0000);
    rd(4'd3, v);  chk("R1 hour", v, 16'h0000);
    rd(4'd4, v);  chk("R1 weekday", v, 16'h0000);
    rd(4'd5, v);  chk("R1 day", v, 16'h0001);
    rd(4'd6, v);  chk("R1 month", v, 16'h0001);
    rd(4'd7, v);  chk("R1 year", v, 16'h2000);
    rd(4'd14, v); chk("R1 ctrl flags", v, 16'h0000);
    rd(4'd15, v); chk("R1 ctrl run", v, 16'h0000);
    chk("R1 irq", {15'd0, carry_irq}, 16'h0000);

    // R2 no counting unless start+enable and reset clear
    ticks(300);
    rd(4'd0, v); chk("R2 stopped subsec", v, 16'h0000);
    rd(4'd1, v); chk("R2 stopped sec", v, 16'h0000);
    wr(4'd15, 16'h0001);
    ticks(200);
    rd(4'd0, v); chk("R2 start only", v, 16'h0000);
    wr(4'd15, 16'h0008);
    ticks(20);
    rd(4'd0, v); chk("R2 enable only", v, 16'h0000);

    // R3 sub-second counting, read-only
    wr(4'd15, 16'h0009);
    ticks(5);
    rd(4'd0, v); chk("R3 subsec count", v, 16'h0005);
    wr(4'd0, 16'h0055);
    rd(4'd0, v); chk("R3 subsec read-only", v, 16'h0005);
    ticks(122);
    rd(4'd0, v); chk("R3 subsec top", v, 16'h007F);
    rd(4'd1, v); chk("R4 sec before wrap", v, 16'h0000);
    ticks(1);
    rd(4'd0, v); chk("R3 subsec wrap", v, 16'h0000);
    rd(4'd1, v); chk("R4 sec advance", v, 16'h0001);

    // R9 flag semantics
    rd(4'd14, v); chk("R9 flag set", v, 16'h0080);
    wr(4'd14, 16'h0080);
    rd(4'd14, v); chk("R9 write one keeps", v, 16'h0080);
    wr(4'd14, 16'h0000);
    rd(4'd14, v); chk("R9 write zero clears", v, 16'h0000);

    // R10 interrupt
    wr(4'd14, 16'h0010);
    chk("R10 irq idle", {15'd0, carry_irq}, 16'h0000);
    ticks(TPS);
    #1 chk("R10 irq raised", {15'd0, carry_irq}, 16'h0001);
    rd(4'd14, v); chk("R10 flag and enable", v, 16'h0090);
    wr(4'd14, 16'h0010);
    #1 chk("R10 irq cleared with flag", {15'd0, carry_irq}, 16'h0000);
    wr(4'd14, 16'h0000);
    ticks(TPS);
    rd(4'd14, v); chk("R10 flag without enable", v, 16'h0080);
    chk("R10 irq masked", {15'd0, carry_irq}, 16'h0000);

    // R11 prescaler reset
    set_time(2023, 6, 15, 4, 12, 0, 0);
    ticks(10);
    rd(4'd0, v); chk("R11 count before reset", v, 16'h000A);
    wr(4'd15, 16'h000B);
    rd(4'd0, v); chk("R11 subsec cleared", v, 16'h0000);
    ticks(300);
    rd(4'd0, v); chk("R11 subsec held", v, 16'h0000);
    rd(4'd1, v); chk("R11 sec held", v, 16'h0000);
    wr(4'd15, 16'h0009);
    ticks(3);
    rd(4'd0, v); chk("R11 resume", v, 16'h0003);

    // R12 writes while running, coincident clear loses to set
    set_time(2023, 6, 15, 4, 12, 20, 10);
    ticks(50);
    wr(4'd2, 16'h0033);
    rd(4'd2, v); chk("R12 running write", v, 16'h0033);
    rd(4'd0, v); chk("R12 count undisturbed", v, 16'h0032);
    ticks(77);
    @(negedge clk);
    tick = 1'b1; we = 1'b1; addr = 4'd14; wdata = 16'h0000;
    @(negedge clk);
    tick = 1'b0; we = 1'b0;
    rd(4'd14, v); chk("R12 set wins over clear", v, 16'h0080);
    rd(4'd1, v);  chk("R12 sec advanced", v, 16'h0011);

    // Directed cascades
    check_next("R4", 2023, 5, 10, 3, 8, 20, 9);
    check_next("R5", 2023, 5, 10, 2, 14, 59, 59);
    check_next("R5", 2023, 5, 10, 6, 23, 59, 59);
    check_next("R6", 2023, 4, 30, 1, 23, 59, 59);
    check_next("R6", 2023, 1, 31, 2, 23, 59, 59);
    check_next("R6", 2023, 11, 30, 4, 23, 59, 59);
    check_next("R6", 2023, 7, 30, 0, 23, 59, 59);
    check_next("R7", 2023, 2, 28, 2, 23, 59, 59);
    check_next("R7", 2024, 2, 28, 3, 23, 59, 59);
    check_next("R7", 2024, 2, 29, 4, 23, 59, 59);
    check_next("R7", 2100, 2, 28, 0, 23, 59, 59);
    check_next("R7", 2000, 2, 28, 1, 23, 59, 59);
    check_next("R8", 2023, 12, 31, 0, 23, 59, 59);
    check_next("R8", 2099, 12, 31, 6, 23, 59, 59);

    // Random dates biased to boundaries
    for (int i = 0; i < 60; i++) begin
      int y, mo, d, wd, h, mi, s;
      y  = 1900 + int'($urandom_range(0, 499));
      mo = ($urandom_range(0, 3) == 0) ? 12 : int'($urandom_range(1, 12));
      d  = ($urandom_range(0, 1) == 0) ? days_in(mo, y) : int'($urandom_range(1, days_in(mo, y)));
      wd = int'($urandom_range(0, 6));
      h  = ($urandom_range(0, 1) == 0) ? 23 : int'($urandom_range(0, 23));
      mi = ($urandom_range(0, 1) == 0) ? 59 : int'($urandom_range(0, 59));
      s  = ($urandom_range(0, 3) != 0) ? 59 : int'($urandom_range(0, 59));
      check_next("R5 random", y, mo, d, wd, h, mi, s);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule